// File: doc/BRIEF.md
# Register Access Protection Checker

This block sits between a command processor and a privileged register space. It decides, in the same cycle, whether each read or write request may go through. A table of protected address ranges decides this. Each slot of the table is one 32-bit word holding a base offset, an inclusive length and a flag. The flag chooses between blocking only writes and blocking every access. A small control register turns checking on, chooses whether a blocked access raises a fault, and can stretch the final slot to the top of the address space.

The table and the control register are loaded through a simple write port. All slots are compared with the request address in parallel. A blocked access produces a one-cycle fault pulse on the next clock edge, if faulting is enabled. The first such fault records its address and direction in a sticky capture. Later faults leave the capture alone until the clear input is pulsed. The table depth is a parameter (32 or 48 slots).

Top module: `regprot_guard`

## Requirements
- R1: A table word holds the base register offset in bits 17:0 and a length in bits 30:18. The range covers base through base+length inclusive, so a length of zero guards exactly one register.
- R2: When bit 31 of a slot is set, both reads and writes inside its range are blocked. When bit 31 is clear, reads pass and only writes are blocked.
- R3: When control bit 0 is clear, every request is allowed, whatever the table holds.
- R4: When control bit 1 is set, a blocked request gives a single-cycle `fault_pulse` on the following clock edge. When control bit 1 is clear, the request is still blocked but no pulse is raised.
- R5: When control bit 3 is set, the slot with index NUM_SLOTS-1 covers everything from its base up to offset 2^18-1 and its length field is ignored. When control bit 3 is clear, that slot uses its length like any other slot.
- R6: A slot that has not been written since reset never matches, so register 0 is not guarded after reset.
- R7: When ranges overlap, a request is blocked if any matching slot forbids it.
- R8: `req_allow` depends combinationally on the request in the same cycle. Table and control writes take effect from the next cycle, so a request presented in the same cycle as a write is judged on the old contents.
- R9: The first fault captures its address and direction (1 = write) and sets `flt_sticky`. Further faults do not change the capture until `flt_clear` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the control register, 1 writes a table slot |
| cfg_idx | input | $clog2(NUM_SLOTS) | Table slot index for a slot write |
| cfg_wdata | input | 32 | Write data: a control value or a table word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 18 | Register offset of the request |
| req_allow | output | 1 | High when a valid request may proceed |
| fault_pulse | output | 1 | One-cycle pulse after a blocked request when faulting is on |
| flt_clear | input | 1 | Clears the sticky fault capture |
| flt_sticky | output | 1 | A fault has been captured |
| flt_addr | output | 18 | Captured faulting offset |
| flt_is_write | output | 1 | Captured direction, 1 = write |

## Verification
The assertions run on every cycle. They check that a disabled checker lets every request through, and that a fault pulse only follows a blocked request while faulting was enabled. They also check that a pulse always leaves the sticky flag set, and that the capture stays frozen until it is cleared. What the assertions cannot show is the range arithmetic: the inclusive end, one-register ranges, overlapping slots with different flags, and the open-ended final slot. They also cannot show that a write and a request in the same cycle see the old table. Address sweeps in the bench show these, comparing the design against a range model built from the requirements.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
    localparam int ADDR_W = 18;
    localparam int LEN_W  = 13;
    localparam int WORD_W = 32;

    localparam int CTL_EN   = 0;
    localparam int CTL_FLT  = 1;
    localparam int CTL_OPEN = 3;

    // Layout matches the table word: [31] block reads too, [30:18] length, [17:0] base
    typedef struct packed {
        logic              no_access;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } slot_word_t;

    typedef struct packed {
        logic en;
        logic flt;
        logic open_end;
    } ctl_t;
endpackage

// File: rtl/regprot_table.sv
module regprot_table
    import regprot_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  slot_word_t                    wr_word,
    output slot_word_t [NUM_SLOTS-1:0]    words,
    output logic       [NUM_SLOTS-1:0]    valid
);
    typedef struct packed {
        slot_word_t [NUM_SLOTS-1:0] w;
        logic       [NUM_SLOTS-1:0] v;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_d.w[i] = wr_word;
                st_d.v[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.w;
    assign valid = st_q.v;
endmodule

// File: rtl/regprot_slot_match.sv
module regprot_slot_match
    import regprot_pkg::*;
#(
    parameter bit IS_LAST = 1'b0
) (
    input  slot_word_t        word,
    input  logic              vld,
    input  logic              open_end,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              hit_rd_block
);
    logic [ADDR_W:0] top_incl;
    logic            lo_ok, hi_ok;

    always_comb begin
        top_incl = {1'b0, word.base} + (ADDR_W+1)'(word.len);
        lo_ok    = addr >= word.base;
        hi_ok    = {1'b0, addr} <= top_incl;
        if (IS_LAST && open_end) hi_ok = 1'b1;
        hit          = vld && lo_ok && hi_ok;
        hit_rd_block = hit && word.no_access;
    end
endmodule

// File: rtl/regprot_guard.sv
module regprot_guard
    import regprot_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_allow,
    output logic              fault_pulse,
    input  logic              flt_clear,
    output logic              flt_sticky,
    output logic [ADDR_W-1:0] flt_addr,
    output logic              flt_is_write
);
    typedef struct packed {
        ctl_t              ctl;
        logic              fault;
        logic              sticky;
        logic [ADDR_W-1:0] faddr;
        logic              fwr;
    } guard_st_t;

    guard_st_t st_d, st_q;

    slot_word_t [NUM_SLOTS-1:0] words;
    logic       [NUM_SLOTS-1:0] valid;
    logic       [NUM_SLOTS-1:0] hit_vec, hit_rd_vec;
    logic                       tbl_wr, blocked, fault_evt;

    assign tbl_wr = cfg_we && cfg_sel;

    regprot_table #(.NUM_SLOTS(NUM_SLOTS)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_idx  (cfg_idx),
        .wr_word (slot_word_t'(cfg_wdata)),
        .words   (words),
        .valid   (valid)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        regprot_slot_match #(.IS_LAST(g == NUM_SLOTS-1)) match_i (
            .word         (words[g]),
            .vld          (valid[g]),
            .open_end     (st_q.ctl.open_end),
            .addr         (req_addr),
            .hit          (hit_vec[g]),
            .hit_rd_block (hit_rd_vec[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        blocked   = st_q.ctl.en && (req_write ? (|hit_vec) : (|hit_rd_vec));
        req_allow = req_valid && !blocked;
        fault_evt = req_valid && blocked && st_q.ctl.flt;

        st_d.fault = fault_evt;
        if (flt_clear) st_d.sticky = 1'b0;
        if (fault_evt && (!st_q.sticky || flt_clear)) begin
            st_d.sticky = 1'b1;
            st_d.faddr  = req_addr;
            st_d.fwr    = req_write;
        end
        if (cfg_we && !cfg_sel) begin
            st_d.ctl.en       = cfg_wdata[CTL_EN];
            st_d.ctl.flt      = cfg_wdata[CTL_FLT];
            st_d.ctl.open_end = cfg_wdata[CTL_OPEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_pulse  = st_q.fault;
    assign flt_sticky   = st_q.sticky;
    assign flt_addr     = st_q.faddr;
    assign flt_is_write = st_q.fwr;

    AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !st_q.ctl.en) |-> req_allow); // R3
    AST_FAULT_FROM_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(req_valid && !req_allow)); // R4
    AST_FAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(st_q.ctl.flt)); // R4
    AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> flt_sticky); // R9
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_sticky && !flt_clear) |=> (flt_sticky && $stable(flt_addr) && $stable(flt_is_write))); // R9
endmodule

// File: tb/regprot_guard_tb_top.sv
module regprot_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int IW = $clog2(NS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_sel = 0, req_valid = 0, req_write = 0, flt_clear = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [17:0] req_addr = '0;
    logic req_allow, fault_pulse, flt_sticky, flt_is_write;
    logic [17:0] flt_addr;

    int n_cmp = 0, n_bad = 0;

    int unsigned m_base [NS];
    int unsigned m_len  [NS];
    bit m_na [NS];
    bit m_vld [NS];
    bit m_en = 0, m_flt = 0, m_open = 0;
    bit e_sticky = 0, e_wr = 0;
    int unsigned e_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regprot_guard #(.NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_allow(req_allow),
        .fault_pulse(fault_pulse), .flt_clear(flt_clear), .flt_sticky(flt_sticky),
        .flt_addr(flt_addr), .flt_is_write(flt_is_write)
    );

    task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_allow(input int unsigned a, input bit wr);
        bit blk = 0;
        if (!m_en) return 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (m_vld[i]) begin
                int unsigned hi = (i == NS-1 && m_open) ? 32'h3FFFF : m_base[i] + m_len[i];
                if (a >= m_base[i] && a <= hi && (wr || m_na[i])) blk = 1;
            end
        end
        return !blk;
    endfunction

    task automatic prog_slot(input int idx, input int unsigned base, input int unsigned len, input bit na);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 1; cfg_idx = IW'(idx);
        cfg_wdata = {na, len[12:0], base[17:0]};
        @(negedge clk);
        cfg_we = 0;
        m_base[idx] = base; m_len[idx] = len; m_na[idx] = na; m_vld[idx] = 1;
    endtask

    task automatic set_ctl(input bit en, input bit flt, input bit open_end);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 0;
        cfg_wdata = 32'(en) | (32'(flt) << 1) | (32'(open_end) << 3);
        @(negedge clk);
        cfg_we = 0;
        m_en = en; m_flt = flt; m_open = open_end;
    endtask

    task automatic access(input int unsigned a, input bit wr, input string req);
        bit ea, ef;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a[17:0];
        ea = exp_allow(a, wr);
        ef = !ea && m_flt;
        #2;
        chk(req_allow === ea, req, {a[23:0], 7'b0, req_allow}, {a[23:0], 7'b0, ea});
        @(posedge clk);
        #1;
        chk(fault_pulse === ef, "R4 fault pulse", {a[23:0], 7'b0, fault_pulse}, {a[23:0], 7'b0, ef});
        if (ef && !e_sticky) begin
            e_sticky = 1; e_addr = a; e_wr = wr;
        end
        req_valid = 0;
    endtask

    task automatic chk_capture(input string req);
        #1;
        chk(flt_sticky === e_sticky, req, flt_sticky, e_sticky);
        if (e_sticky) begin
            chk(flt_addr === e_addr[17:0], req, flt_addr, e_addr);
            chk(flt_is_write === e_wr, req, flt_is_write, e_wr);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_vld[i] = 0; m_base[i] = 0; m_len[i] = 0; m_na[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fault_pulse === 0 && flt_sticky === 0, "reset state", {fault_pulse, flt_sticky}, 0);

        // R6: empty table with checking on guards nothing, not even register 0
        set_ctl(1, 1, 0);
        access(0, 1, "R6 reg0 write after reset");
        access(0, 0, "R6 reg0 read after reset");

        // R1 single register, R2 flags, R7 overlap, R5 last slot with length
        prog_slot(0, 'h010, 0, 0);
        prog_slot(1, 'h020, 'hF, 1);
        prog_slot(2, 'h028, 'h10, 0);
        prog_slot(3, 'h200, 'h3F, 1);
        prog_slot(NS-1, 'h300, 'h7, 0);

        // R3: disabled checker passes everything
        set_ctl(0, 1, 0);
        for (int a = 'h0; a < 'h40; a++) begin
            access(a, 1, "R3 disabled write");
            access(a, 0, "R3 disabled read");
        end

        set_ctl(1, 1, 0);
        for (int a = 0; a < 'h400; a++) begin
            access(a, 0, "R1/R2/R7 read sweep");
            access(a, 1, "R1/R2/R7 write sweep");
        end
        access('h3FFFF, 1, "R5 bounded last slot top write");
        chk_capture("R9 first fault captured");

        // R5: open-ended last slot
        set_ctl(1, 1, 1);
        for (int a = 'h2F0; a < 'h400; a++) begin
            access(a, 0, "R5 open read");
            access(a, 1, "R5 open write");
        end
        access('h20000, 1, "R5 open far write");
        access('h3FFFF, 1, "R5 open top write");
        access('h3FFFF, 0, "R5 open top read");
        chk_capture("R9 capture held");

        // R9: clear then new capture
        @(negedge clk); flt_clear = 1;
        @(negedge clk); flt_clear = 0;
        e_sticky = 0;
        chk_capture("R9 cleared");
        access('h25, 0, "R9 read fault after clear");
        chk_capture("R9 recapture");

        // R4: faulting off, still blocked
        set_ctl(1, 0, 1);
        for (int a = 'h1F8; a < 'h248; a++) access(a, 1, "R4 blocked without fault");
        chk_capture("R9 unchanged when no fault");

        // R8: request in the same cycle as a table write sees old table
        @(negedge clk);
        cfg_we = 1; cfg_sel = 1; cfg_idx = IW'(5); cfg_wdata = {1'b1, 13'd0, 18'h50};
        req_valid = 1; req_write = 1; req_addr = 18'h50;
        #2;
        chk(req_allow === 1'b1, "R8 same-cycle old table", req_allow, 1);
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        m_base[5] = 'h50; m_len[5] = 0; m_na[5] = 1; m_vld[5] = 1;
        access('h50, 1, "R8 new entry next cycle");
        access('h50, 0, "R8 new entry read");
        access('h51, 0, "R1 neighbour unaffected");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule